// File: doc/BRIEF.md
# Receive-Fill RTS/CTS Flow Guard

This block sits beside the receive FIFO of a UART and keeps a remote sender from overrunning it. It watches the FIFO fill count. When automatic mode is on, it drives the RTS line itself. RTS is asserted (logic 1, "stop sending") once the fill reaches the trigger level one step above the programmed one. It is released (logic 0) only after the FIFO drains below the trigger level one step beneath the programmed one. The gap between those two points gives the line hysteresis, so RTS does not chatter while software reads characters one at a time. When automatic mode is off, RTS simply repeats a modem-control bit written by software.

The same block raises a receive-trigger interrupt request whenever the fill is at or above the programmed level. It also produces a transmit-start permit from the CTS input. When automatic CTS handling is on, a new character may leave the transmitter only while CTS is low. The serializer consults the permit only before starting a character, so a character already being shifted out always completes. A 2-bit select picks one of four trigger levels, each computed from the FIFO depth.

Top module: `rxFlowGuard`

## Requirements
- R1: While reset is held, `rtsOut` and `rxTrigIrq` are 0, whatever the other inputs are.
- R2: `trigSel` values 0, 1, 2 and 3 select trigger levels DEPTH/8, DEPTH/4, DEPTH-DEPTH/8 and DEPTH-DEPTH/16. With the default depth of 64, these are 8, 16, 56 and 60.
- R3: With `autoRtsEn`=1, `rtsOut` is 1 on the cycle after a clock edge at which `fifoCount` is at or above the next level above the selected one. For select 3 that level is the selected level itself.
- R4: With `autoRtsEn`=1, `rtsOut` is 0 on the cycle after a clock edge at which `fifoCount` is below the next level beneath the selected one. For select 0 that level is the selected level itself.
- R5: With `autoRtsEn`=1 on consecutive edges and `fifoCount` between the release and trip levels, `rtsOut` keeps its value.
- R6: With `autoRtsEn`=0, `rtsOut` equals the value `swRts` had at the previous clock edge.
- R7: While `autoRtsEn`=0, the automatic state is cleared. After re-enabling with the fill inside the hysteresis band, `rtsOut` is 0.
- R8: `rxTrigIrq` is 1 on the cycle after an edge at which `fifoCount` is at or above the selected level, and 0 otherwise. This holds regardless of `autoRtsEn`.
- R9: `txStartOk` is 0 exactly when `autoCtsEn`=1 and `ctsIn`=1. It responds combinationally, with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| autoRtsEn | input | 1 | Automatic RTS control enable |
| autoCtsEn | input | 1 | Automatic CTS transmit gating enable |
| trigSel | input | 2 | Trigger level select |
| fifoCount | input | CNT_W (7) | Receive FIFO fill count, 0..DEPTH |
| swRts | input | 1 | Software modem-control RTS bit |
| ctsIn | input | 1 | CTS input, 0 = clear to send |
| rtsOut | output | 1 | RTS line, 1 = stop sending |
| rxTrigIrq | output | 1 | Receive trigger interrupt request |
| txStartOk | output | 1 | Permit for the transmitter to start a new character |

## Verification
The hardest state to reach from the ports is the middle of the hysteresis band, where `rtsOut` depends on history rather than on the current fill. This applies especially at the clamped ends of the level list, where the band collapses onto the trigger level. The stimulus ramps the fill count one step at a time from empty to full and back for every select value. Every band point is therefore reached once from below and once from above. A bench-side model predicts the held value at each step. A separate sequence switches automatic mode off and back on while the fill sits inside the band, to show that stale state does not survive.

// File: rtl/rxFlowPkg.sv
package rxFlowPkg;

  typedef struct packed {
    logic geTrip;   // fill at or above the level that asserts RTS
    logic ltFree;   // fill below the level that releases RTS
    logic geTrig;   // fill at or above the selected interrupt level
  } fillFlags_t;

  // Trigger level for select index idx, derived from the FIFO depth.
  function automatic int trigLevel(input int depth, input int idx);
    case (idx)
      0:       return depth / 8;
      1:       return depth / 4;
      2:       return depth - depth / 8;
      default: return depth - depth / 16;
    endcase
  endfunction

endpackage

// File: rtl/rxFlowDatapath.sv
module rxFlowDatapath
  import rxFlowPkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] fifoCount,
  input  logic [1:0]       trigSel,
  output fillFlags_t       flags
);

  localparam int NUM_LVL = 4;

  logic [NUM_LVL-1:0] atOrAbove;
  logic [1:0]         tripIdx;
  logic [1:0]         freeIdx;

  // One comparator per selectable level.
  for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
    localparam logic [CNT_W-1:0] LVL = CNT_W'(trigLevel(DEPTH, i));
    assign atOrAbove[i] = (fifoCount >= LVL);
  end

  // Neighbouring levels clamp at the ends of the list.
  always_comb begin
    tripIdx = (trigSel == 2'd3) ? 2'd3 : trigSel + 2'd1;
    freeIdx = (trigSel == 2'd0) ? 2'd0 : trigSel - 2'd1;
  end

  always_comb begin
    flags.geTrip = atOrAbove[tripIdx];
    flags.ltFree = ~atOrAbove[freeIdx];
    flags.geTrig = atOrAbove[trigSel];
  end

endmodule

// File: rtl/rxFlowControl.sv
module rxFlowControl
  import rxFlowPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       autoRtsEn,
  input  logic       autoCtsEn,
  input  logic       swRts,
  input  logic       ctsIn,
  input  fillFlags_t flags,
  output logic       rtsOut,
  output logic       rxTrigIrq,
  output logic       txStartOk
);

  logic holdQ;
  logic holdNext;
  logic rtsQ;
  logic irqQ;

  always_comb begin
    if (flags.geTrip)      holdNext = 1'b1;
    else if (flags.ltFree) holdNext = 1'b0;
    else                   holdNext = holdQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ <= 1'b0;
      rtsQ  <= 1'b0;
      irqQ  <= 1'b0;
    end else begin
      irqQ <= flags.geTrig;
      if (autoRtsEn) begin
        holdQ <= holdNext;
        rtsQ  <= holdNext;
      end else begin
        holdQ <= 1'b0;
        rtsQ  <= swRts;
      end
    end
  end

  assign rtsOut    = rtsQ;
  assign rxTrigIrq = irqQ;
  assign txStartOk = ~(autoCtsEn & ctsIn);

  // R3: reaching the trip level asserts RTS on the next cycle
  p_rts_trip_r3: assert property (@(posedge clk) disable iff (!rstN)
    (autoRtsEn && flags.geTrip) |=> rtsOut);

  // R4: draining below the release level clears RTS on the next cycle
  p_rts_free_r4: assert property (@(posedge clk) disable iff (!rstN)
    (autoRtsEn && flags.ltFree) |=> !rtsOut);

  // R5: inside the band RTS holds its value
  p_rts_band_r5: assert property (@(posedge clk) disable iff (!rstN)
    (autoRtsEn && $past(autoRtsEn) && !flags.geTrip && !flags.ltFree)
      |=> $stable(rtsOut));

  // R6: manual mode repeats the software bit one cycle later
  p_rts_manual_r6: assert property (@(posedge clk) disable iff (!rstN)
    !autoRtsEn |=> (rtsOut == $past(swRts)));

  // R8: interrupt follows the selected level one cycle later
  p_irq_level_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (rxTrigIrq == $past(flags.geTrig)));

  // R9: CTS high under automatic gating blocks new characters
  p_cts_block_r9: assert property (@(posedge clk) disable iff (!rstN)
    (autoCtsEn && ctsIn) |-> !txStartOk);

endmodule

// File: rtl/rxFlowGuard.sv
module rxFlowGuard
  import rxFlowPkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             autoRtsEn,
  input  logic             autoCtsEn,
  input  logic [1:0]       trigSel,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic             swRts,
  input  logic             ctsIn,
  output logic             rtsOut,
  output logic             rxTrigIrq,
  output logic             txStartOk
);

  fillFlags_t flags;

  rxFlowDatapath #(.DEPTH(DEPTH), .CNT_W(CNT_W)) uDatapath (
    .fifoCount (fifoCount),
    .trigSel   (trigSel),
    .flags     (flags)
  );

  rxFlowControl uControl (
    .clk       (clk),
    .rstN      (rstN),
    .autoRtsEn (autoRtsEn),
    .autoCtsEn (autoCtsEn),
    .swRts     (swRts),
    .ctsIn     (ctsIn),
    .flags     (flags),
    .rtsOut    (rtsOut),
    .rxTrigIrq (rxTrigIrq),
    .txStartOk (txStartOk)
  );

  // R1: outputs stay low while reset is applied
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |-> (!rtsOut && !rxTrigIrq));

endmodule

// File: tb/rxFlowGuard_test.sv
`timescale 1ns/1ps
module rxFlowGuard_test;

  localparam int DEPTH = 64;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic autoRtsEn = 1'b0;
  logic autoCtsEn = 1'b0;
  logic [1:0] trigSel = 2'd0;
  logic [CNT_W-1:0] fifoCount = '0;
  logic swRts = 1'b0;
  logic ctsIn = 1'b0;
  logic rtsOut, rxTrigIrq, txStartOk;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  bit modelHold = 1'b0;

  always #4 clk = ~clk;

  rxFlowGuard #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .autoRtsEn(autoRtsEn), .autoCtsEn(autoCtsEn),
    .trigSel(trigSel), .fifoCount(fifoCount), .swRts(swRts), .ctsIn(ctsIn),
    .rtsOut(rtsOut), .rxTrigIrq(rxTrigIrq), .txStartOk(txStartOk)
  );

  function automatic int lvl(input int idx);
    case (idx)
      0: return DEPTH / 8;
      1: return DEPTH / 4;
      2: return DEPTH - DEPTH / 8;
      default: return DEPTH - DEPTH / 16;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (sel=%0d count=%0d)",
               req, act, exp, trigSel, fifoCount);
    end
  endtask

  // Drive one step at a negedge, check one cycle later.
  task automatic step(input int cnt, input string rtsReq);
    int s;
    int trip;
    int free;
    bit expRts;
    fifoCount = CNT_W'(cnt);
    s = int'(trigSel);
    trip = lvl(s == 3 ? 3 : s + 1);
    free = lvl(s == 0 ? 0 : s - 1);
    if (autoRtsEn) begin
      if (cnt >= trip) modelHold = 1'b1;
      else if (cnt < free) modelHold = 1'b0;
      expRts = modelHold;
    end else begin
      modelHold = 1'b0;
      expRts = swRts;
    end
    @(negedge clk);
    check(rtsReq, int'(rtsOut), int'(expRts));
    check("R8/R2 irq", int'(rxTrigIrq), (cnt >= lvl(s)) ? 1 : 0);
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset holds outputs low even with a full FIFO and auto on
    autoRtsEn = 1'b1;
    swRts = 1'b1;
    fifoCount = CNT_W'(DEPTH);
    repeat (3) @(negedge clk);
    check("R1 rts", int'(rtsOut), 0);
    check("R1 irq", int'(rxTrigIrq), 0);
    fifoCount = '0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R2/R3/R4/R5: full up-and-down ramp for every select value
    for (int s = 0; s < 4; s++) begin
      trigSel = 2'(s);
      step(0, "R4 drain");
      for (int c = 0; c <= DEPTH; c++) step(c, "R3/R5 rise");
      for (int c = DEPTH; c >= 0; c--) step(c, "R4/R5 fall");
    end

    // R6 and R8 in manual mode: RTS follows software, irq still works
    autoRtsEn = 1'b0;
    trigSel = 2'd1;
    for (int c = 0; c <= DEPTH; c += 4) begin
      swRts = c[2];
      step(c, "R6 manual");
    end

    // R7: trip, drop auto, re-enable inside the band
    autoRtsEn = 1'b1;
    swRts = 1'b1;
    step(DEPTH, "R3 trip before R7");
    autoRtsEn = 1'b0;
    swRts = 1'b0;
    step(30, "R6 off");
    autoRtsEn = 1'b1;
    step(30, "R7 re-enable in band");
    step(31, "R7 stays released");

    // R9: CTS gating truth table, combinational
    for (int k = 0; k < 4; k++) begin
      autoCtsEn = k[1];
      ctsIn = k[0];
      #1;
      check("R9 txStartOk", int'(txStartOk), (k == 3) ? 0 : 1);
    end
    // R9: in gating mode the permit follows CTS mid-cycle
    autoCtsEn = 1'b1;
    ctsIn = 1'b0;
    #1 check("R9 cts low", int'(txStartOk), 1);
    ctsIn = 1'b1;
    #1 check("R9 cts high", int'(txStartOk), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule